// File: doc/BRIEF.md
# Three-Bit Gray Code Counter Built From Mixed Storage Stages

This block is a synchronous three-bit counter whose output walks the reflected Gray code: 000, 001, 011, 010, 110, 111, 101, 100, then back to 000. Adjacent codes differ in a single bit, so the count can be sampled in another clock domain or used to drive a position encoder without glitches from several bits switching together.

Each bit lives in a different kind of storage stage. The top bit is held in a J-K stage, the middle bit in a D stage and the bottom bit in a T stage. A combinational excitation network derives J, K, D and T from the present state alone. The network is written as one equation per stage, with no binary counter converted to Gray. A synchronous active-high reset returns the counter to 000. When the count enable is low, the excitations are set so that every stage keeps its value.

Top module: `gray3_mixed_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, `gray_q` becomes 000 after that edge, whatever the value of `cnt_en`.
- R2: When `rst` is low and `cnt_en` is low at a rising edge, `gray_q` keeps its value across that edge.
- R3: With `rst` low and `cnt_en` high, `gray_q` moves one position per rising edge along 000, 001, 011, 010, 110, 111, 101, 100. Codes are written as bit 2, bit 1, bit 0.
- R4: Every counting edge changes exactly one bit of `gray_q`.
- R5: A counting edge from 100 gives 000, so the sequence repeats every 8 counting edges.
- R6: Bit 2 is held by a J-K stage. A counting edge sets it only from 010, clears it only from 100, and otherwise leaves it unchanged.
- R7: Bit 1 is held by a D stage. After a counting edge it equals 1 exactly when the present state was 001, 011, 010 or 110.
- R8: Bit 0 is held by a T stage. It toggles on a counting edge exactly when the present state has an even number of ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to 000 |
| cnt_en | input | 1 | Count enable; low holds the state |
| gray_q | output | 3 | Registered Gray count, bit 2 is the most significant |

## Verification
Reset and count enable can both be high in the same cycle, and reset must win on that edge. The bench raises `rst` together with `cnt_en` at several points along the sequence. It checks that the next sample is 000, and that counting then restarts from 001 rather than from the successor of the interrupted code. Hold and count are also interleaved from a pseudo-random enable pattern. Every stepping edge is then compared against an arithmetically computed Gray code and against per-bit transition rules for each stage type.

// File: rtl/gray3_pkg.sv
package gray3_pkg;
  localparam int GW = 3;
  typedef logic [GW-1:0] gcode_t;

  // excitation bundle for the three stages
  typedef struct packed {
    logic j_hi;
    logic k_hi;
    logic d_mid;
    logic t_lo;
  } excite_t;

  // successor in the reflected code, via binary (used by checks only)
  function automatic gcode_t gray_succ(input gcode_t g);
    gcode_t b;
    gcode_t n;
    b[GW-1] = g[GW-1];
    for (int i = GW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    n = b + 1'b1;
    return n ^ (n >> 1);
  endfunction
endpackage

// File: rtl/stage_jk.sv
module stage_jk (
  input  logic clk,
  input  logic rst,
  input  logic j,
  input  logic k,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else begin
      case ({j, k})
        2'b10:   q <= 1'b1;
        2'b01:   q <= 1'b0;
        2'b11:   q <= ~q;
        default: q <= q;
      endcase
    end
  end

  // R6 stage behaviour
  a_r6_jk_set:    assert property (@(posedge clk) disable iff (rst) (j && !k) |=> q);
  a_r6_jk_clear:  assert property (@(posedge clk) disable iff (rst) (!j && k) |=> !q);
  a_r6_jk_toggle: assert property (@(posedge clk) disable iff (rst) (j && k) |=> (q != $past(q)));
  a_r6_jk_hold:   assert property (@(posedge clk) disable iff (rst) (!j && !k) |=> $stable(q));
endmodule

// File: rtl/stage_d.sv
module stage_d (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end

  // R7 stage behaviour
  a_r7_d_load: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (q == $past(d)));
endmodule

// File: rtl/stage_t.sv
module stage_t (
  input  logic clk,
  input  logic rst,
  input  logic t,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)    q <= 1'b0;
    else if (t) q <= ~q;
  end

  // R8 stage behaviour
  a_r8_t_toggle: assert property (@(posedge clk) disable iff (rst) t |=> (q != $past(q)));
  a_r8_t_hold:   assert property (@(posedge clk) disable iff (rst) !t |=> $stable(q));
endmodule

// File: rtl/gray3_excite.sv
module gray3_excite
  import gray3_pkg::*;
(
  input  gcode_t  cur,
  input  logic    en,
  output excite_t ex
);
  logic a, b, c;
  assign a = cur[2];
  assign b = cur[1];
  assign c = cur[0];

  always_comb begin
    if (en) begin
      ex.j_hi  = b & ~c;                 // set from 010
      ex.k_hi  = ~b & ~c;                // clear from 100
      ex.d_mid = (b & ~c) | (~a & c);
      ex.t_lo  = ~(a ^ b ^ c);           // even parity toggles
    end else begin
      ex.j_hi  = 1'b0;
      ex.k_hi  = 1'b0;
      ex.d_mid = b;
      ex.t_lo  = 1'b0;
    end
  end
endmodule

// File: rtl/gray3_mixed_counter.sv
module gray3_mixed_counter
  import gray3_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_en,
  output logic [GW-1:0] gray_q
);
  excite_t ex;
  logic    q_hi, q_mid, q_lo;

  gray3_excite u_ex (
    .cur (gray_q),
    .en  (cnt_en),
    .ex  (ex)
  );

  stage_jk u_hi (
    .clk (clk), .rst (rst), .j (ex.j_hi), .k (ex.k_hi), .q (q_hi)
  );
  stage_d u_mid (
    .clk (clk), .rst (rst), .d (ex.d_mid), .q (q_mid)
  );
  stage_t u_lo (
    .clk (clk), .rst (rst), .t (ex.t_lo), .q (q_lo)
  );

  assign gray_q = {q_hi, q_mid, q_lo};

  a_r1_reset:    assert property (@(posedge clk) rst |=> (gray_q == '0));
  a_r2_hold:     assert property (@(posedge clk) disable iff (rst) !cnt_en |=> $stable(gray_q));
  a_r3_succ:     assert property (@(posedge clk) disable iff (rst)
                                  cnt_en |=> (gray_q == gray_succ($past(gray_q))));
  a_r4_one_bit:  assert property (@(posedge clk) disable iff (rst)
                                  cnt_en |=> ($countones(gray_q ^ $past(gray_q)) == 1));
  a_r5_wrap:     assert property (@(posedge clk) disable iff (rst)
                                  (cnt_en && gray_q == 3'b100) |=> (gray_q == 3'b000));
endmodule

// File: tb/sim_gray3_mixed_counter.sv
module sim_gray3_mixed_counter;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic [2:0] gray_q;

  int checks = 0;
  int errors = 0;
  logic [2:0] pos;      // binary position in the sequence
  logic [2:0] prev;
  logic [7:0] lfsr = 8'hA5;

  always #(CLK_PERIOD/2) clk = ~clk;

  gray3_mixed_counter u0 (
    .clk (clk), .rst (rst), .cnt_en (cnt_en), .gray_q (gray_q)
  );

  function automatic logic [2:0] to_gray(input logic [2:0] v);
    return v ^ (v >> 1);
  endfunction

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  // apply inputs at a falling edge, sample at the next falling edge
  task automatic step(input logic r, input logic e);
    rst = r;
    cnt_en = e;
    prev = gray_q;
    @(negedge clk);
    if (r) pos = 3'd0;
    else if (e) pos = pos + 3'd1;
  endtask

  task automatic check_count_step();
    logic hi_chg, lo_chg;
    chk("R3", gray_q, to_gray(pos));
    chk("R4", 3'($countones(gray_q ^ prev)), 3'd1);
    if (prev == 3'b100) chk("R5", gray_q, 3'b000);
    hi_chg = (prev == 3'b010) || (prev == 3'b100);
    chk("R6", {2'b0, gray_q[2] ^ prev[2]}, {2'b0, hi_chg});
    chk("R7", {2'b0, gray_q[1]},
        {2'b0, (prev == 3'b001) || (prev == 3'b011) || (prev == 3'b010) || (prev == 3'b110)});
    lo_chg = ~(prev[2] ^ prev[1] ^ prev[0]);
    chk("R8", {2'b0, gray_q[0] ^ prev[0]}, {2'b0, lo_chg});
  endtask

  initial begin
    #(CLK_PERIOD * WD_CYCLES);
    errors++;
    $display("FAIL watchdog R1 actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    pos = 3'd0;
    @(negedge clk);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    chk("R1 reset", gray_q, 3'b000);

    // three full laps with enable high
    for (int i = 0; i < 24; i++) begin
      step(1'b0, 1'b1);
      check_count_step();
    end
    chk("R5 period", gray_q, 3'b000);

    // hold at every code
    for (int i = 0; i < 8; i++) begin
      for (int h = 0; h < 3; h++) begin
        step(1'b0, 1'b0);
        chk("R2 hold", gray_q, prev);
      end
      step(1'b0, 1'b1);
      check_count_step();
    end

    // reset together with enable at each position
    for (int p = 1; p < 8; p++) begin
      for (int s = 0; s < p; s++) begin
        step(1'b0, 1'b1);
        check_count_step();
      end
      step(1'b1, 1'b1);
      chk("R1 reset over enable", gray_q, 3'b000);
      step(1'b0, 1'b1);
      chk("R1 restart", gray_q, 3'b001);
    end

    // pseudo-random enable pattern
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(1'b0, lfsr[0]);
      if (lfsr[0]) check_count_step();
      else chk("R2 random hold", gray_q, prev);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule